// File: doc/BRIEF.md
# Mode Register Write Sequencer

This block sits on the controller side of a graphics DRAM interface and turns a request to program one of the device's two mode registers into a single command cycle on the DRAM pins. A requester presents a valid/ready request that names the target register. For the base register it supplies a ready-made 12-bit word. For the extended register it supplies typed fields: output drive, on-die termination, write recovery, DLL disable, additive latency, vendor-ID enable and low-power enable. The block packs those fields into the 12-bit address word.

Before issuing, the block checks the device state. All banks must be precharged and idle, and clock enable must already be high. For an extended write it also checks that no field holds a reserved code. A request that passes is driven onto the pins for exactly one cycle. The block then stays busy for a fixed completion window and refuses further requests until the window ends. A request that fails produces a one-cycle error pulse and leaves the pins idle.

Top module: `mrs_cmd_issuer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pins show an idle command (chip select, RAS, CAS and WE all high), bank address and address are zero, busy and req_err are low, and req_ready is high.
- R2: A request accepted with req_valid and req_ready both high, and found legal, drives chip select, RAS, CAS and WE all low in the following cycle, for that one cycle only.
- R3: During the command cycle, bank address bit 0 equals req_ext (0 selects the base register, 1 selects the extended register) and bank address bit 1 is 0. For a base write the address equals req_base_word unchanged.
- R4: For an extended write, the address word is built as follows. A1:A0 = cfg_drive (00 auto-calibrated, 01 30 ohm, 10 40 ohm, 11 50 ohm). A3:A2 = cfg_term (00 termination off, 10 ZQ/4, 11 ZQ/2). A4 = cfg_wr_code[0], A5 = cfg_wr_code[1] and A7 = cfg_wr_code[2], where codes 000 to 100 mean 3 to 7 cycles. A6 = cfg_dll_off (1 disables the DLL). A9:A8 = cfg_add_lat (00 means 0, 01 means 1). A10 = cfg_vendor_id. A11 = cfg_low_power.
- R5: busy is high for exactly six consecutive cycles, starting with the command cycle. req_ready is the inverse of busy. No second command appears while busy is high.
- R6: A request accepted while banks_idle or cke_high is low, for either target, is refused. req_err is high for one cycle, in the cycle after acceptance. No command is driven, and busy stays low.
- R7: An extended request is refused in the same way as in R6 if any of these holds: cfg_term is 01, cfg_wr_code is 101, 110 or 111, or cfg_add_lat[1] is 1. The base word is never checked for reserved codes.
- R8: In every cycle other than a command cycle, the pins show an idle command with bank address and address driven to zero.
- R9: req_valid held high while req_ready is low is ignored. The held request is taken at the first cycle in which req_ready is high, and its command appears in the cycle after that.
- R10: A synchronous reset during the completion window clears busy and returns req_ready high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_ext | input | 1 | Target: 0 base register, 1 extended register |
| req_base_word | input | 12 | Word for a base register write |
| cfg_drive | input | 2 | Output drive code |
| cfg_term | input | 2 | Termination code |
| cfg_wr_code | input | 3 | Write recovery code |
| cfg_dll_off | input | 1 | 1 disables the DLL |
| cfg_add_lat | input | 2 | Additive latency code |
| cfg_vendor_id | input | 1 | Vendor ID enable |
| cfg_low_power | input | 1 | Low-power enable |
| banks_idle | input | 1 | All banks precharged and idle |
| cke_high | input | 1 | Clock enable is high |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | 2 | Bank address |
| dram_addr | output | 12 | Address word |
| req_err | output | 1 | One-cycle refusal pulse |
| busy | output | 1 | Completion window in progress |

## Verification
A wrong completion counter shows within seven cycles of a command. busy falls too early or too late, and req_ready returns on the wrong cycle, so a held request issues one cycle off. A misplaced field bit, in particular one of the three scattered write-recovery bits, shows on dram_addr in the very cycle of the command. A faulty legality decision shows in the cycle after acceptance: either a command appears together with an error pulse, or a command appears in place of one. The bench walks vectors that cover each field code, each reserved code and each illegal device state, then holds a request across the window and resets in the middle of it.

// File: rtl/mrs_pkg.sv
// Shared types for the mode register write sequencer.
// Assumes a 12-bit DRAM address bus and a single chip select.
package mrs_pkg;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        DRV_AUTO = 2'b00,
        DRV_30R  = 2'b01,
        DRV_40R  = 2'b10,
        DRV_50R  = 2'b11
    } drive_e;

    typedef enum logic [1:0] {
        TERM_OFF  = 2'b00,
        TERM_RSVD = 2'b01,
        TERM_ZQ4  = 2'b10,
        TERM_ZQ2  = 2'b11
    } term_e;

    typedef struct packed {
        logic       low_power;
        logic       vendor_id;
        logic [1:0] add_lat;
        logic       dll_off;
        logic [2:0] wr_code;
        term_e      term;
        drive_e     drive;
    } ext_cfg_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
endpackage

// File: rtl/mrs_word_build.sv
// Builds the address word for a mode register write and flags reserved codes.
// Purely combinational. Assumes the caller checks device state separately.
// The base word is passed through unchecked; only the extended fields are vetted.
module mrs_word_build
    import mrs_pkg::*;
#(
    parameter int WR_CODE_MAX = 4,
    parameter int AL_CODE_MAX = 1
) (
    input  logic              target_ext,
    input  logic [ADDR_W-1:0] base_word,
    input  ext_cfg_t          cfg,
    output logic [ADDR_W-1:0] word,
    output logic              code_bad
);
    logic [ADDR_W-1:0] ext_word;
    logic              ext_bad;

    // Scatter the extended fields onto their address bits.
    always_comb begin
        ext_word        = '0;
        ext_word[1:0]   = cfg.drive;
        ext_word[3:2]   = cfg.term;
        ext_word[4]     = cfg.wr_code[0];
        ext_word[5]     = cfg.wr_code[1];
        ext_word[6]     = cfg.dll_off;
        ext_word[7]     = cfg.wr_code[2];
        ext_word[9:8]   = cfg.add_lat;
        ext_word[10]    = cfg.vendor_id;
        ext_word[11]    = cfg.low_power;
    end

    // Reserved-code detection for the extended register.
    always_comb begin
        ext_bad = 1'b0;
        if (cfg.term == TERM_RSVD)                   ext_bad = 1'b1;
        if (int'(cfg.wr_code) > WR_CODE_MAX)         ext_bad = 1'b1;
        if (int'(cfg.add_lat) > AL_CODE_MAX)         ext_bad = 1'b1;
    end

    // Select the word and legality for the chosen target.
    always_comb begin
        word     = target_ext ? ext_word : base_word;
        code_bad = target_ext & ext_bad;
    end
endmodule

// File: rtl/mrs_settle_timer.sv
// Completion window counter: counts SETTLE_CYC cycles from each command.
// Assumes start is raised only while the window is closed.
module mrs_settle_timer #(
    parameter int SETTLE_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CNT_W'(SETTLE_CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Window is open while the count is nonzero.
    always_comb busy = (cnt != '0);

    a_r5_start_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    a_r5_open_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/mrs_pin_drive.sv
// Registered DRAM command/address stage. Emits a mode register command for
// one cycle on fire, an idle command otherwise, and a one-cycle error on reject.
// Assumes fire and reject are never high together.
module mrs_pin_drive
    import mrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              reject,
    input  logic              sel_ext,
    input  logic [ADDR_W-1:0] word,
    output cmd_pins_t         pins,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              err
);
    // Register the pin values for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins <= PINS_IDLE;
            ba   <= '0;
            addr <= '0;
            err  <= 1'b0;
        end else begin
            err <= reject;
            if (fire) begin
                pins <= PINS_MODE;
                ba   <= {1'b0, sel_ext};
                addr <= word;
            end else begin
                pins <= PINS_IDLE;
                ba   <= '0;
                addr <= '0;
            end
        end
    end

    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.cs_n |=> pins.cs_n);
    a_r6_err_without_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> pins.cs_n);
    a_r3_ba1_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.cs_n |-> !ba[1]);
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pins.cs_n |-> (ba == 2'b00 && addr == '0 && pins.ras_n && pins.cas_n && pins.we_n));
    a_r7_no_rsvd_term: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins.cs_n && ba[0]) |-> (addr[3:2] != 2'b01));
endmodule

// File: rtl/mrs_cmd_issuer.sv
// Mode register write sequencer top. Accepts a valid/ready request, checks
// device state and reserved codes, issues one command cycle, then holds off
// further requests for SETTLE_CYC cycles. Assumes banks_idle and cke_high are
// already synchronous to clk.
module mrs_cmd_issuer
    import mrs_pkg::*;
#(
    parameter int SETTLE_CYC  = 6,
    parameter int WR_CODE_MAX = 4,
    parameter int AL_CODE_MAX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_ext,
    input  logic [ADDR_W-1:0] req_base_word,
    input  logic [1:0]        cfg_drive,
    input  logic [1:0]        cfg_term,
    input  logic [2:0]        cfg_wr_code,
    input  logic              cfg_dll_off,
    input  logic [1:0]        cfg_add_lat,
    input  logic              cfg_vendor_id,
    input  logic              cfg_low_power,
    input  logic              banks_idle,
    input  logic              cke_high,
    output logic              dram_cs_n,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [1:0]        dram_ba,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              req_err,
    output logic              busy
);
    ext_cfg_t          cfg;
    logic [ADDR_W-1:0] word;
    logic              code_bad;
    logic              accept;
    logic              state_ok;
    logic              fire;
    logic              reject;
    cmd_pins_t         pins;

    // Gather the typed extended configuration.
    always_comb begin
        cfg.drive     = drive_e'(cfg_drive);
        cfg.term      = term_e'(cfg_term);
        cfg.wr_code   = cfg_wr_code;
        cfg.dll_off   = cfg_dll_off;
        cfg.add_lat   = cfg_add_lat;
        cfg.vendor_id = cfg_vendor_id;
        cfg.low_power = cfg_low_power;
    end

    mrs_word_build #(
        .WR_CODE_MAX (WR_CODE_MAX),
        .AL_CODE_MAX (AL_CODE_MAX)
    ) u_word (
        .target_ext (req_ext),
        .base_word  (req_base_word),
        .cfg        (cfg),
        .word       (word),
        .code_bad   (code_bad)
    );

    // Handshake and legality decision.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
        state_ok  = banks_idle && cke_high;
        fire      = accept && state_ok && !code_bad;
        reject    = accept && !fire;
    end

    mrs_settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (fire),
        .busy  (busy)
    );

    mrs_pin_drive u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .reject  (reject),
        .sel_ext (req_ext),
        .word    (word),
        .pins    (pins),
        .ba      (dram_ba),
        .addr    (dram_addr),
        .err     (req_err)
    );

    // Break the pin struct out to plain ports.
    always_comb begin
        dram_cs_n  = pins.cs_n;
        dram_ras_n = pins.ras_n;
        dram_cas_n = pins.cas_n;
        dram_we_n  = pins.we_n;
    end

    a_r6_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cs_n |-> ($past(banks_idle) && $past(cke_high)));
    a_r5_cmd_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cs_n |-> busy);
    a_r5_one_cmd_per_window: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> dram_cs_n);
    a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !req_err);
endmodule

// File: tb/mrs_cmd_issuer_tb.sv
// Self-checking bench: vector table walk, then directed corner cases.
module mrs_cmd_issuer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_ext = 1'b0;
    logic [11:0] req_base_word = '0;
    logic [1:0]  cfg_drive = '0;
    logic [1:0]  cfg_term = '0;
    logic [2:0]  cfg_wr_code = '0;
    logic        cfg_dll_off = 1'b0;
    logic [1:0]  cfg_add_lat = '0;
    logic        cfg_vendor_id = 1'b0;
    logic        cfg_low_power = 1'b0;
    logic        banks_idle = 1'b1;
    logic        cke_high = 1'b1;
    logic        dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
    logic [1:0]  dram_ba;
    logic [11:0] dram_addr;
    logic        req_err;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    mrs_cmd_issuer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ext(req_ext), .req_base_word(req_base_word), .cfg_drive(cfg_drive),
        .cfg_term(cfg_term), .cfg_wr_code(cfg_wr_code), .cfg_dll_off(cfg_dll_off),
        .cfg_add_lat(cfg_add_lat), .cfg_vendor_id(cfg_vendor_id),
        .cfg_low_power(cfg_low_power), .banks_idle(banks_idle), .cke_high(cke_high),
        .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_ba(dram_ba), .dram_addr(dram_addr),
        .req_err(req_err), .busy(busy)
    );

    always #4 clk = ~clk;

    // Vector: {ext, base[11:0], lp, vid, al[1:0], dll, wr[2:0], term[1:0], drv[1:0], idle, cke}
    localparam int NV = 12;
    localparam logic [26:0] VEC [0:NV-1] = '{
        {1'b0, 12'h0a5, 1'b0, 1'b0, 2'b00, 1'b0, 3'b000, 2'b00, 2'b00, 1'b1, 1'b1},
        {1'b1, 12'h000, 1'b0, 1'b0, 2'b00, 1'b0, 3'b000, 2'b10, 2'b01, 1'b1, 1'b1},
        {1'b1, 12'h000, 1'b1, 1'b1, 2'b01, 1'b1, 3'b100, 2'b11, 2'b11, 1'b1, 1'b1},
        {1'b1, 12'h000, 1'b0, 1'b0, 2'b00, 1'b0, 3'b011, 2'b00, 2'b10, 1'b1, 1'b1},
        {1'b1, 12'h000, 1'b0, 1'b0, 2'b00, 1'b0, 3'b000, 2'b01, 2'b00, 1'b1, 1'b1},
        {1'b1, 12'h000, 1'b0, 1'b0, 2'b00, 1'b0, 3'b101, 2'b00, 2'b00, 1'b1, 1'b1},
        {1'b1, 12'h000, 1'b0, 1'b0, 2'b10, 1'b0, 3'b000, 2'b00, 2'b00, 1'b1, 1'b1},
        {1'b0, 12'h3c3, 1'b0, 1'b0, 2'b00, 1'b0, 3'b000, 2'b00, 2'b00, 1'b0, 1'b1},
        {1'b1, 12'h000, 1'b0, 1'b0, 2'b00, 1'b0, 3'b001, 2'b10, 2'b01, 1'b1, 1'b0},
        {1'b0, 12'hfff, 1'b0, 1'b0, 2'b00, 1'b0, 3'b000, 2'b00, 2'b00, 1'b1, 1'b1},
        {1'b1, 12'h000, 1'b0, 1'b0, 2'b00, 1'b0, 3'b111, 2'b00, 2'b00, 1'b1, 1'b1},
        {1'b1, 12'h000, 1'b0, 1'b1, 2'b00, 1'b1, 3'b010, 2'b00, 2'b00, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ext_word(input logic [26:0] v);
        logic [11:0] w;
        w      = '0;
        w[1:0] = v[3:2];
        w[3:2] = v[5:4];
        w[4]   = v[6];
        w[5]   = v[7];
        w[7]   = v[8];
        w[6]   = v[9];
        w[9:8] = v[11:10];
        w[10]  = v[12];
        w[11]  = v[13];
        return w;
    endfunction

    function automatic logic state_good(input logic [26:0] v);
        return v[1] && v[0];
    endfunction

    function automatic logic codes_good(input logic [26:0] v);
        if (!v[26]) return 1'b1;
        if (v[5:4] == 2'b01) return 1'b0;
        if (v[8:6] > 3'd4) return 1'b0;
        if (v[11]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic drive_vec(input logic [26:0] v);
        req_ext       = v[26];
        req_base_word = v[25:14];
        cfg_low_power = v[13];
        cfg_vendor_id = v[12];
        cfg_add_lat   = v[11:10];
        cfg_dll_off   = v[9];
        cfg_wr_code   = v[8:6];
        cfg_term      = v[5:4];
        cfg_drive     = v[3:2];
        banks_idle    = v[1];
        cke_high      = v[0];
    endtask

    task automatic idle_check(input string req);
        chk(req, {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, 4'b1111);
        chk(req, {dram_ba, dram_addr}, 14'h0);
    endtask

    task automatic run_req(input logic [26:0] v);
        logic ok;
        ok = state_good(v) && codes_good(v);
        while (!req_ready) @(negedge clk);
        drive_vec(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        banks_idle = 1'b1;
        cke_high   = 1'b1;
        if (ok) begin
            chk("R2 cmd pins", {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, 4'b0000);
            chk("R3 bank addr", dram_ba, {1'b0, v[26]});
            if (v[26]) chk("R4 ext word", dram_addr, ext_word(v));
            else       chk("R3 base word", dram_addr, v[25:14]);
            chk("R2 no err", req_err, 1'b0);
            chk("R5 busy at cmd", {busy, req_ready}, 2'b10);
            for (int i = 2; i <= 6; i++) begin
                @(negedge clk);
                chk("R5 busy window", {busy, req_ready}, 2'b10);
                idle_check("R8 idle in window");
            end
            @(negedge clk);
            chk("R5 window end", {busy, req_ready}, 2'b01);
        end else begin
            if (!state_good(v)) chk("R6 err pulse", {req_err, dram_cs_n, busy}, 3'b110);
            else                chk("R7 err pulse", {req_err, dram_cs_n, busy}, 3'b110);
            idle_check("R8 idle on reject");
            @(negedge clk);
            chk("R6 err one cycle", req_err, 1'b0);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        idle_check("R1 reset pins");
        chk("R1 reset flags", {busy, req_ready, req_err}, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 after reset");
        chk("R1 after reset flags", {busy, req_ready, req_err}, 3'b010);

        for (int k = 0; k < NV; k++) run_req(VEC[k]);

        // R9: request held across the busy window
        run_req(VEC[1]);
        drive_vec(VEC[2]);
        req_valid = 1'b1;
        @(negedge clk);
        chk("R9 first cmd", dram_cs_n, 1'b0);
        for (int i = 2; i <= 6; i++) begin
            @(negedge clk);
            chk("R9 held while busy", {dram_cs_n, req_err}, 2'b10);
        end
        @(negedge clk);
        chk("R9 ready returns", {req_ready, dram_cs_n}, 2'b11);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 held req issued", dram_cs_n, 1'b0);
        chk("R9 held req word", dram_addr, ext_word(VEC[2]));

        // R10: reset inside the completion window
        repeat (2) @(negedge clk);
        chk("R10 busy before reset", busy, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 busy cleared", {busy, req_ready}, 2'b01);
        idle_check("R10 pins idle");
        rst_n = 1'b1;
        run_req(VEC[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule